// File: doc/BRIEF.md
# In-Order Instruction Fetch Miss Buffer

This block sits between a core's instruction fetch stage and its first-level instruction cache controller. It handles the fetches whose cache lookup has already been resolved. Each fetch carries a sequence number, a byte address and a hit flag from the cache lookup. A miss on a line that has no outstanding miss takes a slot in a small table of outstanding line misses, and a line request goes out to the next level. A later miss on the same line takes no new slot. It is parked in a follower buffer instead. Hits pass straight to the delivery queue, but only when nothing is outstanding.

A refill-completion pulse names a line address and marks the matching table slot as done. Delivery to the consumer is strictly by consecutive sequence number. The oldest table slot is released once it is done and its number is the next one due. Its parked followers follow it as long as their numbers stay consecutive, and all release waits while the delivery queue is full. The consumer drains the queue through a valid/ready pair.

Top module: `fetch_miss_buffer`

## Requirements
- R1: After reset the delivery output is not valid and no line request is raised.
- R2: The line address is the fetch address with its low 6 bits dropped (64-byte lines). A miss on a line not held in the miss table raises miss_req_valid for exactly the next cycle, with that line on miss_req_line. A miss on a held line raises no request.
- R3: The miss table holds at most 8 lines. A miss on a new line is refused (fetch_ready low) while all 8 slots are in use.
- R4: A hit is accepted only when the miss table and the follower buffer are both empty, the delivery queue has room and its sequence number is the next one due. Otherwise fetch_ready is low for it.
- R5: Instructions leave on out_id/out_addr in strictly consecutive sequence-number order, each with the address it was fetched with. A valid output holds steady until out_ready is high.
- R6: A refill marks its slot done, but slots are released only in allocation order. A done slot behind an unfinished one delivers nothing.
- R7: After a slot is released, its parked followers are delivered in consecutive order. A gap in sequence numbers stops all delivery.
- R8: The delivery queue holds 64 entries. While it is full, no hit is accepted and no release happens. Release resumes once the consumer drains the queue.
- R9: The follower buffer holds 16 entries. A same-line miss is refused while it is full, and accepted while only the miss table is full.
- R10: Reset makes sequence number 0 the next one due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A resolved fetch is presented |
| fetch_ready | output | 1 | The presented fetch is taken at this edge |
| fetch_id | input | ID_W | Sequence number of the fetch |
| fetch_addr | input | ADDR_W | Byte address of the fetch |
| fetch_hit | input | 1 | The cache lookup hit |
| refill_valid | input | 1 | A line refill has completed |
| refill_line | input | ADDR_W-6 | Line address of the completed refill |
| miss_req_valid | output | 1 | One-cycle request for a line from the next level |
| miss_req_line | output | ADDR_W-6 | Line address requested |
| out_valid | output | 1 | Delivery queue holds an instruction |
| out_ready | input | 1 | Consumer takes the head instruction |
| out_id | output | ID_W | Sequence number of the head instruction |
| out_addr | output | ADDR_W | Address of the head instruction |

## Verification
Directed sequences come first. A primary miss with a follower, then a hit, tells whether the stall and wake-up of hits is right. Refills for eight distinct lines arrive with the second line refilled first, which separates release in allocation order from release in refill order. A queue held full and a follower buffer filled to the brim check both capacity limits, and a trailing sequence-number gap checks that delivery freezes. A long random stream follows over a small pool of lines, with hit and miss fetches mixed, refills returned in random order and consumer back-pressure. It compares every delivered number and address against the accepted stream.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
    localparam int FMB_ID_W     = 16;
    localparam int FMB_ADDR_W   = 32;
    localparam int FMB_LINE_OFS = 6;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HIT  = 2'd1,
        SRC_MISS = 2'd2,
        SRC_WAIT = 2'd3
    } rel_src_e;
endpackage

// File: rtl/fmb_fifo.sv
module fmb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (st_q.cnt == CW'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign count     = st_q.cnt;
    assign head_data = mem_q[st_q.rd];
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = step(st_q.wr);
        if (do_pop)  st_d.rd = step(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end
endmodule

// File: rtl/fmb_miss_table.sv
module fmb_miss_table #(
    parameter int NUM    = 8,
    parameter int LINE_W = 26,
    parameter int ID_W   = 16,
    parameter int ADDR_W = 32,
    localparam int PW    = $clog2(NUM),
    localparam int CW    = $clog2(NUM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              refill_valid,
    input  logic [LINE_W-1:0] refill_line,
    input  logic [LINE_W-1:0] lookup_line,
    output logic              lookup_hit,
    input  logic              free_head,
    output logic              head_done,
    output logic [ID_W-1:0]   head_id,
    output logic [ADDR_W-1:0] head_addr,
    output logic              full,
    output logic              empty,
    output logic [CW-1:0]     count
);
    typedef struct packed {
        logic              vld;
        logic              done;
        logic [LINE_W-1:0] line;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    typedef struct packed {
        slot_t [NUM-1:0] slot;
        logic [PW-1:0]   hd;
        logic [PW-1:0]   tl;
        logic [CW-1:0]   cnt;
    } tbl_t;

    tbl_t st_d, st_q;
    logic do_alloc, do_free;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(NUM - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (st_q.cnt == CW'(NUM));
    assign empty     = (st_q.cnt == '0);
    assign count     = st_q.cnt;
    assign head_done = st_q.slot[st_q.hd].vld && st_q.slot[st_q.hd].done;
    assign head_id   = st_q.slot[st_q.hd].id;
    assign head_addr = st_q.slot[st_q.hd].addr;
    assign do_alloc  = alloc && !full;
    assign do_free   = free_head && !empty;

    always_comb begin
        lookup_hit = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (st_q.slot[i].vld && (st_q.slot[i].line == lookup_line)) lookup_hit = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM; i++) begin
            if (refill_valid && st_q.slot[i].vld && !st_q.slot[i].done &&
                (st_q.slot[i].line == refill_line)) begin
                st_d.slot[i].done = 1'b1;
            end
        end
        if (do_free) begin
            st_d.slot[st_q.hd].vld  = 1'b0;
            st_d.slot[st_q.hd].done = 1'b0;
            st_d.hd = step(st_q.hd);
        end
        if (do_alloc) begin
            st_d.slot[st_q.tl].vld  = 1'b1;
            st_d.slot[st_q.tl].done = 1'b0;
            st_d.slot[st_q.tl].line = alloc_line;
            st_d.slot[st_q.tl].id   = alloc_id;
            st_d.slot[st_q.tl].addr = alloc_addr;
            st_d.tl = step(st_q.tl);
        end
        case ({do_alloc, do_free})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fetch_miss_buffer.sv
module fetch_miss_buffer
    import fmb_pkg::*;
#(
    parameter int ID_W     = FMB_ID_W,
    parameter int ADDR_W   = FMB_ADDR_W,
    parameter int LINE_OFS = FMB_LINE_OFS,
    parameter int MSHR_N   = 8,
    parameter int WAIT_N   = 16,
    parameter int QUEUE_N  = 64,
    localparam int LINE_W  = ADDR_W - LINE_OFS,
    localparam int ENT_W   = ID_W + ADDR_W,
    localparam int QCNT_W  = $clog2(QUEUE_N + 1),
    localparam int WCNT_W  = $clog2(WAIT_N + 1),
    localparam int MCNT_W  = $clog2(MSHR_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [ID_W-1:0]   fetch_id,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_hit,
    input  logic              refill_valid,
    input  logic [LINE_W-1:0] refill_line,
    output logic              miss_req_valid,
    output logic [LINE_W-1:0] miss_req_line,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ID_W-1:0]   out_id,
    output logic [ADDR_W-1:0] out_addr
);
    typedef struct packed {
        logic [ID_W-1:0]   last;
        logic              mreq_v;
        logic [LINE_W-1:0] mreq_line;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LINE_W-1:0] fetch_line;
    logic [ID_W-1:0]   nxt_id;

    logic              mt_alloc, mt_free, mt_match, mt_full, mt_empty, mt_head_done;
    logic [ID_W-1:0]   mt_head_id;
    logic [ADDR_W-1:0] mt_head_addr;
    logic [MCNT_W-1:0] mt_cnt;

    logic              wf_push, wf_pop, wf_full, wf_empty;
    logic [ENT_W-1:0]  wf_head;
    logic [WCNT_W-1:0] wf_cnt;
    logic [ID_W-1:0]   wf_head_id;

    logic              q_push, q_full, q_empty;
    logic [ENT_W-1:0]  q_din, q_head;
    logic [QCNT_W-1:0] q_cnt;

    logic     ready_hit, ready_wait, ready_alloc;
    rel_src_e src;

    assign fetch_line = fetch_addr[ADDR_W-1:LINE_OFS];
    assign wf_head_id = wf_head[ENT_W-1:ADDR_W];

    fmb_miss_table #(
        .NUM(MSHR_N), .LINE_W(LINE_W), .ID_W(ID_W), .ADDR_W(ADDR_W)
    ) mtab_i (
        .clk(clk), .rst_n(rst_n),
        .alloc(mt_alloc), .alloc_line(fetch_line), .alloc_id(fetch_id), .alloc_addr(fetch_addr),
        .refill_valid(refill_valid), .refill_line(refill_line),
        .lookup_line(fetch_line), .lookup_hit(mt_match),
        .free_head(mt_free), .head_done(mt_head_done),
        .head_id(mt_head_id), .head_addr(mt_head_addr),
        .full(mt_full), .empty(mt_empty), .count(mt_cnt)
    );

    fmb_fifo #(.W(ENT_W), .DEPTH(WAIT_N)) wait_i (
        .clk(clk), .rst_n(rst_n),
        .push(wf_push), .push_data({fetch_id, fetch_addr}),
        .pop(wf_pop), .head_data(wf_head),
        .count(wf_cnt), .full(wf_full), .empty(wf_empty)
    );

    fmb_fifo #(.W(ENT_W), .DEPTH(QUEUE_N)) dq_i (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_data(q_din),
        .pop(out_ready), .head_data(q_head),
        .count(q_cnt), .full(q_full), .empty(q_empty)
    );

    always_comb begin
        ctl_d  = ctl_q;
        nxt_id = ctl_q.last + 1'b1;

        ready_hit   = fetch_hit && mt_empty && wf_empty && !q_full && (fetch_id == nxt_id);
        ready_wait  = !fetch_hit && mt_match && !wf_full;
        ready_alloc = !fetch_hit && !mt_match && !mt_full;

        src = SRC_NONE;
        if (!q_full) begin
            if (!mt_empty && mt_head_done && (mt_head_id == nxt_id))  src = SRC_MISS;
            else if (!wf_empty && (wf_head_id == nxt_id))            src = SRC_WAIT;
            else if (fetch_valid && ready_hit)                        src = SRC_HIT;
        end

        case (src)
            SRC_MISS: q_din = {mt_head_id, mt_head_addr};
            SRC_WAIT: q_din = wf_head;
            default:  q_din = {fetch_id, fetch_addr};
        endcase

        q_push   = (src != SRC_NONE);
        mt_free  = (src == SRC_MISS);
        wf_pop   = (src == SRC_WAIT);
        wf_push  = fetch_valid && ready_wait;
        mt_alloc = fetch_valid && ready_alloc;

        if (q_push) ctl_d.last = q_din[ENT_W-1:ADDR_W];
        ctl_d.mreq_v = mt_alloc;
        if (mt_alloc) ctl_d.mreq_line = fetch_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.last      <= '1;
            ctl_q.mreq_v    <= 1'b0;
            ctl_q.mreq_line <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fetch_ready    = ready_hit || ready_wait || ready_alloc;
    assign miss_req_valid = ctl_q.mreq_v;
    assign miss_req_line  = ctl_q.mreq_line;
    assign out_valid      = !q_empty;
    assign out_id         = q_head[ENT_W-1:ADDR_W];
    assign out_addr       = q_head[ADDR_W-1:0];
endmodule

// File: rtl/fmb_checker.sv
module fmb_checker #(
    parameter int ID_W     = 16,
    parameter int ADDR_W   = 32,
    parameter int LINE_OFS = 6,
    parameter int QUEUE_N  = 64,
    parameter int MCNT_W   = 4,
    parameter int QCNT_W   = 7,
    parameter int MSHR_N   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fetch_valid,
    input logic                       fetch_ready,
    input logic                       fetch_hit,
    input logic [ADDR_W-1:0]          fetch_addr,
    input logic                       mt_match,
    input logic                       mt_full,
    input logic                       mt_empty,
    input logic                       wf_empty,
    input logic [MCNT_W-1:0]          mt_cnt,
    input logic [QCNT_W-1:0]          q_cnt,
    input logic                       miss_req_valid,
    input logic [ADDR_W-LINE_OFS-1:0] miss_req_line,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [ID_W-1:0]            out_id
);
    logic            seen_q;
    logic [ID_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            prev_q <= '0;
        end else if (out_valid && out_ready) begin
            seen_q <= 1'b1;
            prev_q <= out_id;
        end
    end

    // R3
    mshr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mt_cnt <= MCNT_W'(MSHR_N));

    // R3
    mshr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_full && !fetch_hit && !mt_match) |-> !fetch_ready);

    // R4
    hit_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hit && (!mt_empty || !wf_empty)) |-> !fetch_ready);

    // R2
    miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && !fetch_hit && !mt_match) |=>
        (miss_req_valid && miss_req_line == $past(fetch_addr[ADDR_W-1:LINE_OFS])));

    // R5
    out_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && seen_q) |-> (out_id == prev_q + 1'b1));

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_id)));

    // R8
    q_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt == QCNT_W'(QUEUE_N)) |=> (q_cnt <= $past(q_cnt)));
endmodule

bind fetch_miss_buffer fmb_checker #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .QUEUE_N(QUEUE_N),
    .MCNT_W(MCNT_W), .QCNT_W(QCNT_W), .MSHR_N(MSHR_N)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_hit(fetch_hit),
    .fetch_addr(fetch_addr), .mt_match(mt_match), .mt_full(mt_full),
    .mt_empty(mt_empty), .wf_empty(wf_empty), .mt_cnt(mt_cnt), .q_cnt(q_cnt),
    .miss_req_valid(miss_req_valid), .miss_req_line(miss_req_line),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id)
);

// File: tb/fetch_miss_buffer_tb.sv
`timescale 1ns/1ps
module fetch_miss_buffer_tb_top;
    localparam int ID_W = 16, ADDR_W = 32, LW = 26, WAIT_N = 16, QUEUE_N = 64, MSHR_N = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fetch_valid = 1'b0, fetch_hit = 1'b0, fetch_ready;
    logic [ID_W-1:0] fetch_id = '0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic refill_valid = 1'b0;
    logic [LW-1:0] refill_line = '0;
    logic miss_req_valid;
    logic [LW-1:0] miss_req_line;
    logic out_valid, out_ready = 1'b0;
    logic [ID_W-1:0] out_id;
    logic [ADDR_W-1:0] out_addr;

    always #2 clk = ~clk;

    fetch_miss_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_id(fetch_id),
        .fetch_addr(fetch_addr), .fetch_hit(fetch_hit),
        .refill_valid(refill_valid), .refill_line(refill_line),
        .miss_req_valid(miss_req_valid), .miss_req_line(miss_req_line),
        .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_addr(out_addr)
    );

    int checks = 0, fails = 0;
    int next_out = 0, nid = 0, mreq_cnt = 0;
    logic [LW-1:0] last_mreq_line = '0;
    logic [ADDR_W-1:0] exp_addr [1024];
    bit auto_refill = 0, rand_ready = 0, finished = 0;
    logic [LW-1:0] pend [$];

    function automatic logic [LW-1:0] line_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:6];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic try_fetch(input int id, input logic [ADDR_W-1:0] a, input bit h, output bit acc);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_id = ID_W'(id); fetch_addr = a; fetch_hit = h;
        #1 acc = fetch_ready;
        if (acc) exp_addr[id] = a;
        @(posedge clk);
        #1 fetch_valid = 1'b0;
    endtask

    task automatic probe(input int id, input logic [ADDR_W-1:0] a, input bit h, output bit r);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_id = ID_W'(id); fetch_addr = a; fetch_hit = h;
        #1 r = fetch_ready;
    endtask

    task automatic do_refill(input logic [LW-1:0] l);
        @(negedge clk);
        #0.5 refill_line = l; refill_valid = 1'b1;
    endtask

    // monitor: delivery order/data and line requests
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready) begin
            chk(out_id == ID_W'(next_out), "R5 order", out_id, next_out);
            chk(out_addr == exp_addr[out_id], "R5 addr", out_addr, exp_addr[out_id]);
            next_out++;
        end
        if (rst_n && miss_req_valid) begin
            mreq_cnt++;
            last_mreq_line = miss_req_line;
            if (auto_refill) pend.push_back(miss_req_line);
        end
    end

    // refill responder and consumer back-pressure
    always @(negedge clk) begin
        refill_valid = 1'b0;
        if (rand_ready) out_ready = ($urandom % 4) != 0;
        if (auto_refill && pend.size() > 0 && ($urandom % 3) == 0) begin
            int idx;
            idx = int'($urandom % pend.size());
            refill_line = pend[idx];
            refill_valid = 1'b1;
            pend.delete(idx);
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", next_out, nid);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a, r;
        int m0, acc_n;
        void'($urandom(32'd2024));
        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        #1;
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(miss_req_valid == 1'b0, "R1 miss_req", miss_req_valid, 0);
        // R10 id 0 next; R4 wrong id refused
        probe(0, 32'h1000, 1, r); chk(r == 1, "R10 id0 due", r, 1);
        probe(1, 32'h1000, 1, r); chk(r == 0, "R4 id not due", r, 0);

        // primary miss and follower
        out_ready = 1'b1;
        try_fetch(0, 32'h1000, 0, a); chk(a == 1, "R2 primary accept", a, 1);
        try_fetch(1, 32'h1008, 0, a); chk(a == 1, "R2 follower accept", a, 1);
        cycles(2);
        chk(mreq_cnt == 1, "R2 single request", mreq_cnt, 1);
        chk(last_mreq_line == line_of(32'h1000), "R2 line", last_mreq_line, line_of(32'h1000));
        probe(2, 32'h1010, 1, r); chk(r == 0, "R4 hit stalls", r, 0);
        cycles(4);
        chk(next_out == 0, "R6 nothing before refill", next_out, 0);
        do_refill(line_of(32'h1000));
        cycles(6);
        chk(next_out == 2, "R7 follower released", next_out, 2);
        try_fetch(2, 32'h1010, 1, a); chk(a == 1, "R4 hit accepted", a, 1);
        cycles(3);
        chk(next_out == 3, "R4 hit delivered", next_out, 3);
        nid = 3;

        // capacity and allocation order
        m0 = mreq_cnt;
        for (int k = 0; k < MSHR_N; k++) begin
            try_fetch(nid + k, 32'h2000 + 32'(k * 64), 0, a);
            chk(a == 1, "R3 slot accept", a, 1);
        end
        probe(nid + 8, 32'h3000, 0, r); chk(r == 0, "R3 full refuse", r, 0);
        probe(nid + 8, 32'h2004, 0, r); chk(r == 1, "R9 follower while table full", r, 1);
        cycles(2);
        chk(mreq_cnt - m0 == MSHR_N, "R2 eight requests", mreq_cnt - m0, MSHR_N);
        do_refill(line_of(32'h2040));
        cycles(5);
        chk(next_out == nid, "R6 out of order refill held", next_out, nid);
        do_refill(line_of(32'h2000));
        cycles(5);
        chk(next_out == nid + 2, "R6 head then next", next_out, nid + 2);
        for (int k = 2; k < MSHR_N; k++) do_refill(line_of(32'h2000 + 32'(k * 64)));
        cycles(10);
        chk(next_out == nid + 8, "R6 all released", next_out, nid + 8);
        nid += 8;

        // delivery queue full
        out_ready = 1'b0;
        acc_n = 0;
        for (int i = 0; i < QUEUE_N; i++) begin
            try_fetch(nid + i, 32'h4000 + 32'(i * 4), 1, a);
            if (a) acc_n++;
        end
        chk(acc_n == QUEUE_N, "R8 64 accepted", acc_n, QUEUE_N);
        nid += QUEUE_N;
        probe(nid, 32'h4100, 1, r); chk(r == 0, "R8 hit refused when full", r, 0);
        #1;
        chk(out_valid == 1 && out_id == ID_W'(next_out), "R5 head held", out_id, next_out);
        try_fetch(nid, 32'h5000, 0, a); chk(a == 1, "R8 miss still accepted", a, 1);
        do_refill(line_of(32'h5000));
        cycles(5);
        chk(next_out == nid - QUEUE_N, "R8 no release while full", next_out, nid - QUEUE_N);
        out_ready = 1'b1;
        cycles(80);
        chk(next_out == nid + 1, "R8 resumes", next_out, nid + 1);
        nid++;

        // follower buffer full
        try_fetch(nid, 32'h6000, 0, a);
        for (int j = 0; j < WAIT_N; j++) begin
            try_fetch(nid + 1 + j, 32'h6000 + 32'((j + 1) * 2), 0, a);
            chk(a == 1, "R9 follower accept", a, 1);
        end
        probe(nid + 1 + WAIT_N, 32'h6030, 0, r); chk(r == 0, "R9 follower refused", r, 0);
        do_refill(line_of(32'h6000));
        cycles(30);
        nid += 1 + WAIT_N;
        chk(next_out == nid, "R7 all followers out", next_out, nid);

        // random phase
        auto_refill = 1; rand_ready = 1;
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] ad;
            bit h;
            ad = 32'h8000 + 32'(($urandom % 12) * 64) + 32'(($urandom % 16) * 4);
            h = ($urandom % 10) < 4;
            a = 0;
            while (!a) try_fetch(nid, ad, h, a);
            nid++;
        end
        for (int w = 0; w < 3000 && next_out != nid; w++) cycles(1);
        chk(next_out == nid, "R5 random stream complete", next_out, nid);

        // gap in sequence numbers freezes delivery
        try_fetch(nid + 1, 32'h9000, 0, a); chk(a == 1, "R7 gap miss accepted", a, 1);
        cycles(40);
        #1;
        chk(out_valid == 0 && next_out == nid, "R7 gap stops delivery", next_out, nid);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule